// File: doc/BRIEF.md
# Remote Line Cache Tag Controller

This block holds the tags and per-line states of a cache that keeps copies of memory lines whose home is in another node. The data itself sits in an external memory; this block only says whether a request can be answered from that memory and which slot of it to use. Each tag entry covers an aligned pair of lines (two sectors). Each sector carries its own state: invalid, shared or exclusive. The tags are organised as 128 sets of 8 ways.

Four kinds of request arrive, one per cycle at most. A read for a shared copy hits when its sector is valid, and is then completed locally. A miss is sent on to the remote home. A request for write permission always goes to the remote home. The cache never satisfies it, and it drops any local copy of the sector. A fill installs the data of a remote read response as shared. A dirty eviction from a local processor installs the line as exclusive. Installs reuse the way that already holds the pair's tag. Otherwise they take the lowest-numbered empty way, or the least recently used way of a full set. Every request gets one registered answer in the following cycle.

Top module: `remote_tag_ctrl`

## Requirements
- R1: Each request with `reqValid` high produces exactly one cycle of `rspValid` on the next clock cycle. `rspValid` is low in every other cycle.
- R2: The request address is `{tag, set[6:0], sector}`, with the sector in bit 0 and the set in bits 7:1. A read-shared request (`reqOp` 0) whose sector is valid gives `rspLocal`=1 and `rspForward`=0. It also gives `rspState` as the sector's state, and `rspSlot` = {set, way[2:0], sector}.
- R3: A read-shared request whose sector is invalid or whose tag is absent gives `rspForward`=1, `rspLocal`=0, `rspSlot`=0 and `rspState`=0 (invalid).
- R4: A fill (`reqOp` 2) sets the addressed sector to shared (`rspState` code 1 on a later read). It reports the slot written, with `rspLocal`=`rspForward`=0 and `rspState` equal to the sector's prior state.
- R5: A dirty eviction (`reqOp` 3) sets the addressed sector to exclusive (code 2), even over a shared copy. It reports the same way as a fill.
- R6: A write-permission request (`reqOp` 1) always gives `rspForward`=1, `rspLocal`=0 and `rspSlot`=0, whether or not the line is cached. `rspState` reports the sector's prior state.
- R7: A write-permission request invalidates only the addressed sector. A later read of that sector misses, and the other sector of the pair is unaffected.
- R8: An install whose tag is already resident in the set, with either sector valid, writes into that same way.
- R9: An install with a new tag takes the lowest-numbered way whose two sectors are both invalid. In a full set it takes the least recently used way. Read hits and installs make a way most recently used; write-permission requests and misses do not.
- R10: When a new tag takes a way, both sectors of the old entry become invalid, and so does the unwritten sector of the new entry.
- R11: After reset every sector is invalid, so every read misses, and no response is pending.
- R12: `rspLocal` and `rspForward` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 read-shared, 1 write-permission, 2 fill, 3 dirty eviction |
| reqAddr | input | 20 | Line address {tag, set, sector} |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspLocal | output | 1 | Request served from the local cache |
| rspForward | output | 1 | Request must go to the remote home |
| rspState | output | 2 | Sector state found at lookup (0 invalid, 1 shared, 2 exclusive) |
| rspSlot | output | 11 | Data slot {set, way, sector}, zero when not used |

## Verification
A wrong sector state shows at the ports the next time that sector is read. A sector dropped by mistake turns a hit into a forward with `rspState` 0. A wrong state code appears directly in `rspState`. A fault in the replacement order stays hidden until a set fills up. It then shows as a wrong way field in `rspSlot` on the install, or as a hit or miss on the wrong old line one request later. For this reason the stimulus fills sets completely and then reads every displaced sector right away.

// File: rtl/rtag_pkg.sv
package rtag_pkg;

  typedef enum logic [1:0] {
    OP_READ_SH    = 2'd0,
    OP_WRITE_PERM = 2'd1,
    OP_FILL       = 2'd2,
    OP_DIRTY_EVICT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } sec_state_e;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic       alloc;      // claim victim way for a new tag
    logic       wrSec;      // write addressed sector state
    sec_state_e newState;
    logic       touch;      // make chosen way most recently used
    logic       outLocal;
    logic       outForward;
    logic       outSlot;    // report slot of chosen way
  } strobe_t;

endpackage

// File: rtl/rtag_control.sv
module rtag_control
  import rtag_pkg::*;
(
  input  op_e        op,
  input  logic       tagHit,
  input  sec_state_e foundState,
  output strobe_t    stb
);

  logic secHit;
  assign secHit = tagHit && (foundState != ST_INV);

  always_comb begin
    stb = '0;
    stb.newState = ST_INV;
    unique case (op)
      OP_READ_SH: begin
        stb.outLocal   = secHit;
        stb.outForward = !secHit;
        stb.touch      = secHit;
        stb.outSlot    = secHit;
      end
      OP_WRITE_PERM: begin
        stb.outForward = 1'b1;
        stb.wrSec      = secHit;
        stb.newState   = ST_INV;
      end
      OP_FILL: begin
        stb.alloc    = !tagHit;
        stb.wrSec    = 1'b1;
        stb.newState = ST_SHR;
        stb.touch    = 1'b1;
        stb.outSlot  = 1'b1;
      end
      OP_DIRTY_EVICT: begin
        stb.alloc    = !tagHit;
        stb.wrSec    = 1'b1;
        stb.newState = ST_EXC;
        stb.touch    = 1'b1;
        stb.outSlot  = 1'b1;
      end
      default: stb = '0;
    endcase
  end

endmodule

// File: rtl/rtag_datapath.sv
module rtag_datapath
  import rtag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SETS   = 128,
  parameter int WAYS   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  strobe_t                  stb,
  output logic                     tagHit,
  output sec_state_e               foundState,
  output logic                     rspValid,
  output logic                     rspLocal,
  output logic                     rspForward,
  output logic [1:0]               rspState,
  output logic [$clog2(SETS)+$clog2(WAYS):0] rspSlot
);

  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W - 1;
  localparam int SLOT_W = SET_W + WAY_W + 1;

  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [1:0]       secSt  [SETS][WAYS][2];
  logic [WAY_W-1:0] ageMem [SETS][WAYS];

  logic [SET_W-1:0] curSet;
  logic [TAG_W-1:0] curTag;
  logic             curSec;

  assign curSec = reqAddr[0];
  assign curSet = reqAddr[SET_W:1];
  assign curTag = reqAddr[ADDR_W-1:SET_W+1];

  logic [WAYS-1:0] wayValid, wayMatch, wayOld;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign wayValid[g] = (secSt[curSet][g][0] != ST_INV) ||
                           (secSt[curSet][g][1] != ST_INV);
      assign wayMatch[g] = wayValid[g] && (tagMem[curSet][g] == curTag);
      assign wayOld[g]   = (ageMem[curSet][g] == WAY_W'(WAYS - 1));
    end
  endgenerate

  logic [WAY_W-1:0] hitWay, freeWay, oldWay, useWay;
  logic             anyFree;

  always_comb begin
    tagHit  = 1'b0;
    hitWay  = '0;
    anyFree = 1'b0;
    freeWay = '0;
    oldWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) begin
        tagHit = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!wayValid[w]) begin
        anyFree = 1'b1;
        freeWay = WAY_W'(w);
      end
      if (wayOld[w]) oldWay = WAY_W'(w);
    end
  end

  assign useWay     = tagHit ? hitWay : (anyFree ? freeWay : oldWay);
  assign foundState = tagHit ? sec_state_e'(secSt[curSet][hitWay][curSec]) : ST_INV;

  // sector states and recency order
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          secSt[s][w][0] <= ST_INV;
          secSt[s][w][1] <= ST_INV;
          ageMem[s][w]   <= WAY_W'(w);
        end
      end
    end else if (reqValid) begin
      if (stb.alloc) begin
        secSt[curSet][useWay][0] <= ST_INV;
        secSt[curSet][useWay][1] <= ST_INV;
      end
      if (stb.wrSec) secSt[curSet][useWay][curSec] <= stb.newState;
      if (stb.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == useWay)
            ageMem[curSet][w] <= '0;
          else if (ageMem[curSet][w] < ageMem[curSet][useWay])
            ageMem[curSet][w] <= ageMem[curSet][w] + 1'b1;
        end
      end
    end
  end

  // tag storage needs no reset: a way is live only through its sector states
  always_ff @(posedge clk) begin
    if (reqValid && stb.alloc) tagMem[curSet][useWay] <= curTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspLocal   <= 1'b0;
      rspForward <= 1'b0;
      rspState   <= ST_INV;
      rspSlot    <= '0;
    end else begin
      rspValid   <= reqValid;
      rspLocal   <= reqValid && stb.outLocal;
      rspForward <= reqValid && stb.outForward;
      rspState   <= reqValid ? foundState : ST_INV;
      rspSlot    <= (reqValid && stb.outSlot) ? SLOT_W'({curSet, useWay, curSec}) : '0;
    end
  end

endmodule

// File: rtl/remote_tag_ctrl.sv
module remote_tag_ctrl
  import rtag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SETS   = 128,
  parameter int WAYS   = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                reqValid,
  input  logic [1:0]                          reqOp,
  input  logic [ADDR_W-1:0]                   reqAddr,
  output logic                                rspValid,
  output logic                                rspLocal,
  output logic                                rspForward,
  output logic [1:0]                          rspState,
  output logic [$clog2(SETS)+$clog2(WAYS):0]  rspSlot
);

  strobe_t    stb;
  logic       tagHit;
  sec_state_e foundState;

  rtag_control u_ctrl (
    .op         (op_e'(reqOp)),
    .tagHit     (tagHit),
    .foundState (foundState),
    .stb        (stb)
  );

  rtag_datapath #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqAddr    (reqAddr),
    .stb        (stb),
    .tagHit     (tagHit),
    .foundState (foundState),
    .rspValid   (rspValid),
    .rspLocal   (rspLocal),
    .rspForward (rspForward),
    .rspState   (rspState),
    .rspSlot    (rspSlot)
  );

endmodule

// File: rtl/remote_tag_ctrl_chk.sv
module remote_tag_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int SETS   = 128,
  parameter int WAYS   = 8
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               reqValid,
  input logic [1:0]                         reqOp,
  input logic [ADDR_W-1:0]                  reqAddr,
  input logic                               rspValid,
  input logic                               rspLocal,
  input logic                               rspForward,
  input logic [1:0]                         rspState,
  input logic [$clog2(SETS)+$clog2(WAYS):0] rspSlot
);

  localparam int SET_W  = $clog2(SETS);
  localparam int SLOT_W = SET_W + $clog2(WAYS) + 1;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R1
  AST_LOCAL_HAS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLocal) |-> (rspState != 2'd0));  // R2
  AST_MISS_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspForward) |-> (rspSlot == '0));  // R3
  AST_WRPERM_FORWARDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd1) |=> (rspForward && !rspLocal));  // R6
  AST_INSTALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp[1]) |=> (!rspForward && !rspLocal));  // R4
  AST_INSTALL_SLOT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp[1]) |=>
      (rspSlot[0] == $past(reqAddr[0]) &&
       rspSlot[SLOT_W-1 -: SET_W] == $past(reqAddr[SET_W:1])));  // R8
  AST_LOCAL_FORWARD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspLocal && rspForward));  // R12

endmodule

bind remote_tag_ctrl remote_tag_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .SETS   (SETS),
  .WAYS   (WAYS)
) u_chk (.*);

// File: tb/remote_tag_ctrl_test.sv
module remote_tag_ctrl_test;

  localparam int ADDR_W = 20;
  localparam int SETS   = 128;
  localparam int WAYS   = 8;
  localparam int SET_W  = 7;
  localparam int WAY_W  = 3;
  localparam int TAG_W  = ADDR_W - SET_W - 1;
  localparam int SLOT_W = SET_W + WAY_W + 1;
  localparam int EXP_W  = 4 + SLOT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic rspValid, rspLocal, rspForward;
  logic [1:0] rspState;
  logic [SLOT_W-1:0] rspSlot;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  remote_tag_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspLocal(rspLocal), .rspForward(rspForward),
    .rspState(rspState), .rspSlot(rspSlot)
  );

  // reference model of the requirements
  int mTag [SETS][WAYS];
  int mSt  [SETS][WAYS][2];
  int mAge [SETS][WAYS];

  logic [EXP_W-1:0] expQ[$];
  string            reqQ[$];

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mTag[s][w] = -1; mSt[s][w][0] = 0; mSt[s][w][1] = 0; mAge[s][w] = w;
      end
  endtask

  task automatic touch(input int s, input int w);
    int ref_age = mAge[s][w];
    for (int v = 0; v < WAYS; v++)
      if (mAge[s][v] < ref_age) mAge[s][v] = mAge[s][v] + 1;
    mAge[s][w] = 0;
  endtask

  // driver: computes expectation, queues it, presents the request for one cycle
  task automatic issue(input int op, input int tg, input int st, input int sc, input string rq);
    int hw = -1;
    int way;
    int found;
    logic lcl = 1'b0, fwd = 1'b0;
    logic [SLOT_W-1:0] slot = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mTag[st][w] == tg && (mSt[st][w][0] != 0 || mSt[st][w][1] != 0)) hw = w;
    found = (hw >= 0) ? mSt[st][hw][sc] : 0;
    case (op)
      0: begin
        if (hw >= 0 && found != 0) begin
          lcl = 1'b1; slot = SLOT_W'(st * 16 + hw * 2 + sc); touch(st, hw);
        end else fwd = 1'b1;
      end
      1: begin
        fwd = 1'b1;
        if (hw >= 0 && found != 0) mSt[st][hw][sc] = 0;
      end
      default: begin
        way = hw;
        if (way < 0) begin
          for (int w = WAYS - 1; w >= 0; w--)
            if (mSt[st][w][0] == 0 && mSt[st][w][1] == 0) way = w;
          if (way < 0)
            for (int w = 0; w < WAYS; w++) if (mAge[st][w] == WAYS - 1) way = w;
          mSt[st][way][0] = 0; mSt[st][way][1] = 0; mTag[st][way] = tg;
        end
        mSt[st][way][sc] = (op == 2) ? 1 : 2;
        touch(st, way);
        slot = SLOT_W'(st * 16 + way * 2 + sc);
      end
    endcase
    expQ.push_back({lcl, fwd, 2'(found), slot});
    reqQ.push_back(rq);
    reqValid = 1'b1;
    reqOp    = 2'(op);
    reqAddr  = {TAG_W'(tg), SET_W'(st), sc[0]};
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares one expectation per response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      logic [EXP_W-1:0] got, exp_v;
      string rq;
      checks++;
      got = {rspLocal, rspForward, rspState, rspSlot};
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response got %h exp none", got);
      end else begin
        exp_v = expQ.pop_front();
        rq = reqQ.pop_front();
        if (got !== exp_v) begin
          errors++;
          $display("FAIL %s local/fwd/state/slot got %h exp %h", rq, got, exp_v);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R11: nothing pending during and right after reset
    checks++;
    if (rspValid !== 1'b0 || rspLocal !== 1'b0 || rspForward !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset outputs got %b%b%b exp 000", rspValid, rspLocal, rspForward);
    end
    rstN = 1'b1;
    @(negedge clk);

    issue(0, 5, 3, 0, "R11");      // empty cache misses
    issue(2, 5, 3, 0, "R4");       // fill -> shared, way 0
    issue(0, 5, 3, 0, "R2");       // hit, state 1
    issue(0, 5, 3, 1, "R3");       // other sector still invalid
    issue(3, 5, 3, 1, "R8");       // same tag, same way, sector 1
    issue(0, 5, 3, 1, "R5");       // exclusive, state 2
    issue(3, 5, 3, 0, "R5");       // dirty over shared
    issue(0, 5, 3, 0, "R5");
    issue(1, 5, 3, 0, "R6");       // write permission forwards, reports 2
    issue(0, 5, 3, 0, "R7");       // now misses
    issue(0, 5, 3, 1, "R7");       // neighbour sector kept
    issue(1, 9, 3, 0, "R6");       // uncached write permission
    idle(2);
    checks++;
    if (rspValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle response got %b exp 0", rspValid);
    end

    // fill set 10 completely, oldest entry holds both sectors
    issue(2, 1, 10, 0, "R9");
    issue(3, 1, 10, 1, "R8");
    for (int t = 2; t <= 8; t++) issue(2, t, 10, 0, "R9");
    issue(2, 9, 10, 1, "R9");      // evicts LRU way 0
    issue(0, 1, 10, 0, "R10");
    issue(0, 1, 10, 1, "R10");
    issue(0, 9, 10, 0, "R10");
    issue(0, 9, 10, 1, "R2");
    issue(0, 2, 10, 0, "R9");      // refresh way 1
    issue(1, 3, 10, 0, "R9");      // write permission does not refresh
    issue(2, 10, 10, 0, "R9");     // victim follows recency
    issue(0, 3, 10, 0, "R9");
    issue(0, 2, 10, 0, "R9");
    issue(0, 4, 10, 0, "R9");

    // mixed traffic on a few crowded sets, back to back and with gaps
    for (int i = 0; i < 1500; i++) begin
      int op = int'($urandom_range(0, 3));
      string rq;
      case (op)
        0: rq = "R2";
        1: rq = "R7";
        2: rq = "R4";
        default: rq = "R5";
      endcase
      issue(op, int'($urandom_range(0, 11)), int'($urandom_range(0, 2)),
            int'($urandom_range(0, 1)), rq);
      if ($urandom_range(0, 7) == 0) idle(1);
    end

    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses got %0d left exp 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule